// File: doc/BRIEF.md
# Adaptive-threshold lane peak detector

The block scans one image row of 64 pixels at a time and marks the pixels that look like the centre of a painted lane marking. Each incoming pixel is first smoothed over a three-pixel window. A pixel is then flagged as a peak when its smoothed value stands out from its smoothed neighbours and also clears a brightness threshold. Every pixel gets exactly one result bit, and the results come out in a fixed-latency stream.

The threshold is not a constant. Any row can be tagged as a sample row, and the block averages that row's raw pixels. It then compares the average with four programmable reference levels. The reference that the average reaches picks one of four programmable threshold levels. The new choice is switched in when the next row starts, so a whole row is always judged against one threshold.

A row is streamed as 64 valid pixels on consecutive clock cycles. The first pixel of the row carries the row-start flag. Idle cycles may fall between rows, and the next row may also follow the previous one directly.

Top module: `lane_peak_det`

## Requirements
- R1: The pixel index is 0 on a valid cycle with `row_start_i` high, and it increases by one on each following valid cycle. A row is 64 valid pixels on consecutive cycles. Rows may be separated by any number of idle cycles, zero included.
- R2: The smoothed value of pixel k is floor((p[k-1] + 2*p[k] + p[k+1]) / 4). At pixel 0 the missing left neighbour is replaced by p[0]. At pixel 63 the missing right neighbour is replaced by p[63].
- R3: Pixel k is a peak when three conditions hold: s[k] >= s[k-1], s[k] > s[k+1] (strict), and s[k] > the active threshold.
- R4: Pixels 0 and 63 always give a result of 0.
- R5: For a sample row, avg = floor(sum of its 64 pixels / 64). The selected index is the highest i in 0..3 with avg >= reference field i. If no field qualifies, index 0 is selected. Reference field i is `ref_lvl_i[8i+7:8i]`. The active threshold is field `sel` of `thr_lvl_i`, using the same bit layout.
- R6: A selection made by a sample row takes effect at the next row start. The sample row itself and any earlier rows use the previous selection. After reset the selection is index 0.
- R7: `peak_valid_o` is high exactly 3 clock cycles after each valid input pixel. `peak_o` then carries that pixel's result, and it is 0 whenever `peak_valid_o` is low.
- R8: During reset and directly after it, `peak_valid_o` and `peak_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel strobe |
| row_start_i | input | 1 | Marks pixel 0 of a row |
| sample_row_i | input | 1 | With row_start_i: this row feeds the brightness average |
| pix_i | input | 8 | Pixel value |
| ref_lvl_i | input | 32 | Four 8-bit reference levels, field i at bits 8i+7:8i |
| thr_lvl_i | input | 32 | Four 8-bit threshold levels, same layout |
| peak_valid_o | output | 1 | Result strobe |
| peak_o | output | 1 | 1 when the pixel is a lane peak |

## Verification
The hardest case to reach is a row start that arrives while the previous row's last pixels are still in the pipeline. This is also the moment when a new threshold selection is being switched in. The end-of-row results must still be judged against the old level, and the new row must get the new one. The stimulus sends a sample row followed directly by a row with graded bumps. The bumps' smoothed heights fall between neighbouring threshold levels, so the expected peaks differ depending on which level is applied. Random rows with random sample flags and random idle gaps of zero to four cycles then revisit this handover many times.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  localparam int unsigned PIX_W_D   = 8;
  localparam int unsigned ROW_LEN_D = 64;  // must be a power of two
  localparam int unsigned N_REF_D   = 4;
endpackage

// File: rtl/lpd_smooth.sv
module lpd_smooth #(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned ROW_LEN = 64,
  localparam int unsigned IDX_W  = $clog2(ROW_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_valid_i,
  input  logic [IDX_W-1:0] pix_idx_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             sm_v_o,
  output logic [IDX_W-1:0] sm_idx_o,
  output logic [PIX_W-1:0] sm_o,
  output logic [PIX_W-1:0] nx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROW_LEN - 1);

  logic             c_v_q;
  logic [IDX_W-1:0] c_idx_q;
  logic [PIX_W-1:0] c_pix_q, l_pix_q;
  logic [PIX_W-1:0] left, right;
  logic [PIX_W+1:0] sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_v_q   <= 1'b0;
      c_idx_q <= '0;
      c_pix_q <= '0;
      l_pix_q <= '0;
      sm_v_o  <= 1'b0;
      sm_idx_o <= '0;
      sm_o    <= '0;
    end else begin
      c_v_q    <= pix_valid_i;
      c_idx_q  <= pix_idx_i;
      c_pix_q  <= pix_i;
      l_pix_q  <= c_pix_q;
      sm_v_o   <= c_v_q;
      sm_idx_o <= c_idx_q;
      sm_o     <= nx_o;
    end
  end

  // window centre is the registered pixel; the live input is its right side
  assign left  = (c_idx_q == '0)  ? c_pix_q : l_pix_q;
  assign right = (c_idx_q == LAST) ? c_pix_q : pix_i;
  assign sum   = {2'b00, left} + {1'b0, c_pix_q, 1'b0} + {2'b00, right};
  assign nx_o  = sum[PIX_W+1:2];
endmodule

// File: rtl/lpd_thresh.sv
module lpd_thresh #(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned ROW_LEN = 64,
  parameter int unsigned N_REF   = 4,
  localparam int unsigned IDX_W  = $clog2(ROW_LEN),
  localparam int unsigned SUM_W  = PIX_W + IDX_W,
  localparam int unsigned SEL_W  = (N_REF > 1) ? $clog2(N_REF) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   row_go_i,
  input  logic                   sample_row_i,
  input  logic                   pix_valid_i,
  input  logic                   last_i,
  input  logic [PIX_W-1:0]       pix_i,
  input  logic [N_REF*PIX_W-1:0] ref_lvl_i,
  input  logic [N_REF*PIX_W-1:0] thr_lvl_i,
  output logic [PIX_W-1:0]       thr_o,
  output logic [SEL_W-1:0]       sel_o
);
  logic             samp_q, samp_act;
  logic [SUM_W-1:0] acc_q, acc_base, acc_tot;
  logic [PIX_W-1:0] avg;
  logic [SEL_W-1:0] pick, pend_sel_q;
  logic             pend_q;

  assign samp_act = row_go_i ? sample_row_i : samp_q;
  assign acc_base = row_go_i ? '0 : acc_q;
  assign acc_tot  = acc_base + SUM_W'(pix_i);
  assign avg      = acc_tot[SUM_W-1:IDX_W];

  // later fields win: highest reference index reached
  always_comb begin
    pick = '0;
    for (int i = 0; i < int'(N_REF); i++) begin
      if (avg >= ref_lvl_i[i*PIX_W +: PIX_W]) pick = SEL_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q     <= 1'b0;
      acc_q      <= '0;
      pend_q     <= 1'b0;
      pend_sel_q <= '0;
      sel_o      <= '0;
    end else begin
      if (row_go_i) samp_q <= sample_row_i;
      if (pix_valid_i && samp_act) acc_q <= acc_tot;
      if (row_go_i && pend_q) begin
        sel_o  <= pend_sel_q;
        pend_q <= 1'b0;
      end
      if (pix_valid_i && samp_act && last_i) begin
        pend_sel_q <= pick;
        pend_q     <= 1'b1;
      end
    end
  end

  assign thr_o = thr_lvl_i[sel_o*PIX_W +: PIX_W];
endmodule

// File: rtl/lpd_peak.sv
module lpd_peak #(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned ROW_LEN = 64,
  localparam int unsigned IDX_W  = $clog2(ROW_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sm_v_i,
  input  logic [IDX_W-1:0] sm_idx_i,
  input  logic [PIX_W-1:0] sm_i,
  input  logic [PIX_W-1:0] nx_i,
  input  logic [PIX_W-1:0] thr_i,
  output logic             peak_valid_o,
  output logic             peak_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROW_LEN - 1);

  logic [PIX_W-1:0] prev_q;
  logic             inner, hit;

  assign inner = (sm_idx_i != '0) && (sm_idx_i != LAST);
  assign hit   = sm_v_i && inner && (sm_i >= prev_q) && (sm_i > nx_i) && (sm_i > thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q       <= '0;
      peak_valid_o <= 1'b0;
      peak_o       <= 1'b0;
    end else begin
      prev_q       <= sm_i;
      peak_valid_o <= sm_v_i;
      peak_o       <= hit;
    end
  end
endmodule

// File: rtl/lane_peak_det.sv
module lane_peak_det #(
  parameter int unsigned PIX_W   = lpd_pkg::PIX_W_D,
  parameter int unsigned ROW_LEN = lpd_pkg::ROW_LEN_D,
  parameter int unsigned N_REF   = lpd_pkg::N_REF_D,
  localparam int unsigned IDX_W  = $clog2(ROW_LEN),
  localparam int unsigned SEL_W  = (N_REF > 1) ? $clog2(N_REF) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pix_valid_i,
  input  logic                   row_start_i,
  input  logic                   sample_row_i,
  input  logic [PIX_W-1:0]       pix_i,
  input  logic [N_REF*PIX_W-1:0] ref_lvl_i,
  input  logic [N_REF*PIX_W-1:0] thr_lvl_i,
  output logic                   peak_valid_o,
  output logic                   peak_o
);
  logic [IDX_W-1:0] cnt_q, idx_in, sm_idx;
  logic             row_go, last_in, sm_v;
  logic [PIX_W-1:0] sm_val, nx_val, thr_w;
  logic [SEL_W-1:0] sel_w;

  assign idx_in  = row_start_i ? '0 : cnt_q;
  assign row_go  = pix_valid_i && row_start_i;
  assign last_in = (idx_in == IDX_W'(ROW_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (pix_valid_i) cnt_q <= idx_in + 1'b1;
  end

  lpd_smooth #(.PIX_W(PIX_W), .ROW_LEN(ROW_LEN)) u_smooth (
    .clk_i, .rst_ni,
    .pix_valid_i,
    .pix_idx_i (idx_in),
    .pix_i,
    .sm_v_o    (sm_v),
    .sm_idx_o  (sm_idx),
    .sm_o      (sm_val),
    .nx_o      (nx_val)
  );

  lpd_thresh #(.PIX_W(PIX_W), .ROW_LEN(ROW_LEN), .N_REF(N_REF)) u_thresh (
    .clk_i, .rst_ni,
    .row_go_i     (row_go),
    .sample_row_i,
    .pix_valid_i,
    .last_i       (last_in),
    .pix_i,
    .ref_lvl_i,
    .thr_lvl_i,
    .thr_o        (thr_w),
    .sel_o        (sel_w)
  );

  lpd_peak #(.PIX_W(PIX_W), .ROW_LEN(ROW_LEN)) u_peak (
    .clk_i, .rst_ni,
    .sm_v_i   (sm_v),
    .sm_idx_i (sm_idx),
    .sm_i     (sm_val),
    .nx_i     (nx_val),
    .thr_i    (thr_w),
    .peak_valid_o,
    .peak_o
  );
endmodule

// File: rtl/lane_peak_det_chk.sv
module lane_peak_det_chk #(
  parameter int unsigned ROW_LEN = 64,
  parameter int unsigned SEL_W   = 2,
  localparam int unsigned IDX_W  = $clog2(ROW_LEN)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_valid_i,
  input logic             row_start_i,
  input logic             peak_valid_o,
  input logic             peak_o,
  input logic [SEL_W-1:0] sel_i
);
  logic [IDX_W-1:0] ci_q, ci_in;
  logic [2:0]       vp_q;
  logic [IDX_W-1:0] ip_q [3];

  assign ci_in = row_start_i ? '0 : ci_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ci_q <= '0;
      vp_q <= '0;
      for (int i = 0; i < 3; i++) ip_q[i] <= '0;
    end else begin
      if (pix_valid_i) ci_q <= ci_in + 1'b1;
      vp_q  <= {vp_q[1:0], pix_valid_i};
      ip_q[0] <= ci_in;
      ip_q[1] <= ip_q[0];
      ip_q[2] <= ip_q[1];
    end
  end

  p_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peak_valid_o == vp_q[2]);

  p_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !peak_valid_o |-> !peak_o);

  p_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (peak_valid_o && (ip_q[2] == '0 || ip_q[2] == IDX_W'(ROW_LEN - 1))) |-> !peak_o);

  p_sel_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pix_valid_i && row_start_i) |=> $stable(sel_i));
endmodule

bind lane_peak_det lane_peak_det_chk #(.ROW_LEN(ROW_LEN), .SEL_W(SEL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pix_valid_i  (pix_valid_i),
  .row_start_i  (row_start_i),
  .peak_valid_o (peak_valid_o),
  .peak_o       (peak_o),
  .sel_i        (sel_w)
);

// File: tb/sim_lane_peak_det.sv
`timescale 1ns/1ps
module sim_lane_peak_det;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        vin = 1'b0, rs = 1'b0, sr = 1'b0;
  logic [7:0]  pin = '0;
  logic [31:0] refc = {8'd160, 8'd120, 8'd80, 8'd40};
  logic [31:0] thrc = {8'd120, 8'd90, 8'd60, 8'd30};
  logic        pv, pk;

  lane_peak_det u0 (
    .clk_i(clk), .rst_ni(rst_n), .pix_valid_i(vin), .row_start_i(rs),
    .sample_row_i(sr), .pix_i(pin), .ref_lvl_i(refc), .thr_lvl_i(thrc),
    .peak_valid_o(pv), .peak_o(pk)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int px [64];
  int sel_m = 0, pend_m = 0, pend_sel_m = 0;
  int    q_cyc [$];
  bit    q_bit [$];
  int    q_idx [$];
  string q_tag [$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic pop();
    void'(q_cyc.pop_front()); void'(q_bit.pop_front());
    void'(q_idx.pop_front()); void'(q_tag.pop_front());
  endtask

  always @(negedge clk) if (rst_n) begin
    while (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
      chk(1'b0, "R7", $sformatf("missing result idx %0d", q_idx[0]), 0, 1);
      pop();
    end
    if (pv) begin
      if (q_cyc.size() == 0) chk(1'b0, "R7", "unexpected result", 1, 0);
      else begin
        chk(q_cyc[0] == cyc, "R7", "result cycle", cyc, q_cyc[0]);
        chk(pk == q_bit[0], q_tag[0], $sformatf("peak idx %0d", q_idx[0]), int'(pk), int'(q_bit[0]));
        pop();
      end
    end else if (pk) chk(1'b0, "R7", "peak without valid", 1, 0);
  end

  function automatic int fld(logic [31:0] v, int i);
    return int'(v[i*8 +: 8]);
  endfunction

  function automatic int smv(int k);
    int l, r;
    l = (k == 0)  ? px[0]  : px[k-1];
    r = (k == 63) ? px[63] : px[k+1];
    return (l + 2*px[k] + r) / 4;
  endfunction

  task automatic send_row(bit samp, int gap, string tag);
    int thr, sum, avg;
    int s [64];
    bit e;
    if (pend_m != 0) begin sel_m = pend_sel_m; pend_m = 0; end
    thr = fld(thrc, sel_m);
    for (int k = 0; k < 64; k++) s[k] = smv(k);
    for (int k = 0; k < 64; k++) begin
      e = (k > 0) && (k < 63) && (s[k] >= s[k-1]) && (s[k] > s[k+1]) && (s[k] > thr);
      @(negedge clk);
      vin = 1'b1; rs = (k == 0); sr = samp; pin = 8'(px[k]);
      q_cyc.push_back(cyc + 3); q_bit.push_back(e); q_idx.push_back(k);
      q_tag.push_back((k == 0 || k == 63) ? "R4" : tag);
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk); vin = 1'b0; rs = 1'b0; sr = 1'b0;
    end
    if (samp) begin
      sum = 0;
      for (int k = 0; k < 64; k++) sum += px[k];
      avg = sum / 64;
      pend_sel_m = 0;
      for (int i = 0; i < 4; i++) if (avg >= fld(refc, i)) pend_sel_m = i;
      pend_m = 1;
    end
  endtask

  task automatic fill(int v);
    for (int k = 0; k < 64; k++) px[k] = v;
  endtask

  task automatic bumps();
    fill(0);
    px[10] = 50; px[20] = 90; px[30] = 150; px[40] = 210; px[50] = 255;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) if (cyc == 150000) begin
    chk(1'b0, "R7", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(pv == 1'b0, "R8", "valid in reset", int'(pv), 0);
    chk(pk == 1'b0, "R8", "peak in reset", int'(pk), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(pv == 1'b0, "R8", "valid after reset", int'(pv), 0);
    chk(pk == 1'b0, "R8", "peak after reset", int'(pk), 0);

    // spike and flat-topped plateau
    fill(50); px[20] = 200; px[40] = 150; px[41] = 150;
    send_row(1'b0, 2, "R3");
    // truncation right at threshold 30: 61 -> 30, 62 -> 31
    fill(0); px[10] = 61; px[30] = 62; px[50] = 63;
    send_row(1'b0, 1, "R2");
    // bright edges
    fill(10); px[0] = 255; px[63] = 255;
    send_row(1'b0, 3, "R4");
    // bright sample row, then back-to-back row judged on the new level
    fill(130); px[20] = 255; px[30] = 0; px[31] = 0; px[32] = 100; px[33] = 0; px[34] = 0;
    send_row(1'b1, 0, "R6");
    bumps(); send_row(1'b0, 0, "R6");
    // average below every reference
    fill(5); send_row(1'b1, 2, "R5");
    bumps(); send_row(1'b0, 2, "R5");
    // average exactly on the top and on a middle reference
    fill(160); send_row(1'b1, 0, "R5");
    bumps(); send_row(1'b0, 1, "R5");
    fill(80); send_row(1'b1, 1, "R5");
    bumps(); send_row(1'b0, 0, "R5");

    for (int r = 0; r < 40; r++) begin
      int base;
      base = int'($urandom_range(0, 200));
      for (int k = 0; k < 64; k++) px[k] = base + int'($urandom_range(0, 55));
      if ($urandom_range(0, 3) == 0) px[$urandom_range(0, 63)] = 255;
      send_row(1'($urandom_range(0, 2) == 0), int'($urandom_range(0, 4)), "R1");
    end

    @(negedge clk); vin = 1'b0; rs = 1'b0; sr = 1'b0;
    repeat (8) @(negedge clk);
    chk(q_cyc.size() == 0, "R7", "results outstanding", q_cyc.size(), 0);
    finish_run();
  end
endmodule